// File: doc/BRIEF.md
# Armed Pulse Decimation Counter

This block divides an external strobe by a programmable ratio. It stays idle until a start command arms it. After that it counts strobe events, and on the event that reaches the programmed ratio it produces a single-cycle done pulse. It then returns to idle and ignores further strobes until it is armed again. Typical use is to gate a downstream engine so that it starts only after a given number of periodic trigger pulses have arrived since a start request.

Both the strobe and the start input may be asynchronous to the system clock. Each passes through a two-flop synchronizer. The synchronized strobe then feeds a rising-edge detector, so a strobe that stays high for many clocks counts exactly once. The strobe never acts as a clock: every state change happens on the system clock edge. The ratio input is 16 bits wide and must be held stable while a count is in progress.

Top module: `decim_counter`

## Requirements
- R1: While idle (after reset or after a done pulse), strobe edges are not counted and done_o stays low, however many strobes arrive.
- R2: Once armed, each low-to-high transition of strobe_i counts as exactly one event, whether strobe_i then stays high for 1 clock or for many clocks. strobe_i must be low for at least one clock between events.
- R3: With ratio_i = N (N >= 2), done_o goes high for exactly one clock on the N-th counted event after arming, and the block returns to idle in the same cycle.
- R4: A ratio_i of 0 or 1 makes the block fire on the first event after arming.
- R5: If strobe_i is first sampled high at clock edge k and that event is the terminal one, done_o is high after edge k+2 and low again after edge k+3. A start_i first sampled high at edge k arms the block after edge k+2, and a strobe first sampled at edge k+1 or later is counted.
- R6: Asserting start_i while counting has no effect: the event count is neither restarted nor changed.
- R7: Driving rst_ni low (active low, asynchronous), even in the middle of a count, forces idle, drives done_o low and clears the event count. The next count after re-arming starts from zero.
- R8: After a done pulse, further strobe events produce no further pulse until start_i is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Asynchronous event strobe to be decimated |
| start_i | input | 1 | Asynchronous arm request |
| ratio_i | input | 16 | Decimation ratio N; must be held stable while counting |
| done_o | output | 1 | One-cycle pulse on the N-th event after arming |

## Verification
A done pulse appears after the third clock edge that samples the strobe high: two edges pass through the synchronizer and one through the counter register. Arming takes two edges to reach the counter and applies after the third. The bench drives all inputs on the falling edge. It gives each arm four clocks to settle and each strobe at least one low clock before the next. It counts done pulses on falling edges, so a pulse is seen exactly once. The latency case then walks the edges one falling edge at a time and expects done_o low, low, high, low after the first, second, third and fourth rising edge.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int unsigned RATIO_W = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } decim_state_e;
endpackage

// File: rtl/decim_sync.sv
module decim_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/decim_edge.sv
module decim_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/decim_fsm.sv
module decim_fsm
  import decim_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o
);
  decim_state_e     state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] last_idx;
  logic             done_q;

  // ratios 0 and 1 both terminate on the first event
  assign last_idx = (ratio_i == '0) ? '0 : ratio_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (arm_i) state_q <= ST_COUNT;
        end
        ST_COUNT: begin
          if (evt_i) begin
            if (idx_q == last_idx) begin
              done_q  <= 1'b1;
              idx_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_COUNT);
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/decim_counter.sv
module decim_counter
  import decim_pkg::*;
#(
  parameter int unsigned CNT_W  = RATIO_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             done_o
);
  localparam int unsigned N_ASYNC = 2;

  logic [N_ASYNC-1:0] raw_in;
  logic [N_ASYNC-1:0] sync_in;
  logic               strobe_s;
  logic               arm_s;
  logic               evt;
  logic               busy;
  logic [CNT_W-1:0]   idx;

  assign raw_in   = {start_i, strobe_i};
  assign strobe_s = sync_in[0];
  assign arm_s    = sync_in[1];

  decim_sync #(
    .WIDTH (N_ASYNC),
    .STAGES(STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  decim_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (strobe_s),
    .rise_o(evt)
  );

  decim_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_s),
    .evt_i  (evt),
    .ratio_i(ratio_i),
    .busy_o (busy),
    .idx_o  (idx),
    .done_o (done_o)
  );
endmodule

// File: rtl/decim_counter_chk.sv
module decim_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm,
  input logic             evt,
  input logic             busy,
  input logic [CNT_W-1:0] idx,
  input logic             done_o
);
  // R1
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !arm) |=> (!busy && !done_o));

  // R1
  idle_idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (idx == '0) || busy);

  // R2
  no_evt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !evt) |=> ($stable(idx) && busy && !done_o));

  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy && idx == '0));

  // R6
  rearm_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && arm && !evt) |=> (busy && $stable(idx)));

  // R8
  done_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy));
endmodule

bind decim_counter decim_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .arm   (arm_s),
  .evt   (evt),
  .busy  (busy),
  .idx   (idx),
  .done_o(done_o)
);

// File: tb/decim_counter_bench.sv
module decim_counter_bench;
  localparam int NV = 8;
  // ratio, strobes, strobe high width, expected done pulses
  localparam int VEC [NV][4] = '{
    '{1, 1, 3, 1},
    '{0, 1, 3, 1},
    '{3, 2, 3, 0},
    '{3, 3, 3, 1},
    '{5, 5, 1, 1},
    '{5, 8, 2, 1},
    '{2, 4, 10, 1},
    '{4, 3, 10, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ratio = 16'd1;
  logic        done;

  int n_run = 0;
  int n_fail = 0;
  int done_cnt = 0;

  always #10 clk = ~clk;

  decim_counter u_decim_counter (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .strobe_i(strobe),
    .start_i (start),
    .ratio_i (ratio),
    .done_o  (done)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    strobe = 1'b0;
    start = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic arm();
    start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(4);
  endtask

  task automatic pulse(input int hi, input int lo);
    strobe = 1'b1;
    tick(hi);
    strobe = 1'b0;
    tick(lo);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) pulse(hi, lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    tick(2);
    chk(int'(done), 0, "R7 reset state");
    rst_n = 1'b1;
    tick(1);

    // R1: strobes without arming
    ratio = 16'd1;
    base = done_cnt;
    pulses(5, 2, 2);
    tick(6);
    chk(done_cnt - base, 0, "R1 no arm");

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      ratio = 16'(VEC[v][0]);
      arm();
      base = done_cnt;
      pulses(VEC[v][1], VEC[v][2], 2);
      tick(6);
      chk(done_cnt - base, VEC[v][3], $sformatf("R2 R3 R4 R8 vector %0d", v));
    end

    // R5: exact latency, ratio 1
    do_reset();
    ratio = 16'd1;
    arm();
    strobe = 1'b1;
    tick(1);
    chk(int'(done), 0, "R5 after k");
    tick(1);
    chk(int'(done), 0, "R5 after k+1");
    tick(1);
    chk(int'(done), 1, "R5 after k+2");
    tick(1);
    chk(int'(done), 0, "R5 after k+3");
    strobe = 1'b0;
    tick(4);

    // R5: strobe one clock after start still counts
    do_reset();
    ratio = 16'd1;
    base = done_cnt;
    start = 1'b1;
    tick(1);
    start = 1'b0;
    strobe = 1'b1;
    tick(3);
    strobe = 1'b0;
    tick(6);
    chk(done_cnt - base, 1, "R5 strobe after start");

    // R6: re-arm while counting does not restart
    do_reset();
    ratio = 16'd3;
    arm();
    base = done_cnt;
    pulse(3, 2);
    arm();
    pulses(2, 3, 2);
    tick(6);
    chk(done_cnt - base, 1, "R6 start ignored");

    // R7: reset mid-count restarts from zero
    do_reset();
    ratio = 16'd3;
    arm();
    pulses(2, 3, 2);
    do_reset();
    chk(int'(done), 0, "R7 done low after reset");
    arm();
    base = done_cnt;
    pulse(3, 2);
    tick(6);
    chk(done_cnt - base, 0, "R7 count cleared");
    pulses(2, 3, 2);
    tick(6);
    chk(done_cnt - base, 1, "R7 fires after full count");

    // R3: large ratio, single-clock strobes, no early fire
    do_reset();
    ratio = 16'd300;
    arm();
    base = done_cnt;
    pulses(299, 1, 1);
    tick(6);
    chk(done_cnt - base, 0, "R3 299 of 300");
    pulse(1, 1);
    tick(6);
    chk(done_cnt - base, 1, "R3 300 of 300");

    // R8: re-arm after done works again
    ratio = 16'd2;
    pulses(3, 2, 2);
    tick(4);
    chk(done_cnt - base, 1, "R8 idle after done");
    arm();
    pulses(2, 2, 2);
    tick(6);
    chk(done_cnt - base, 2, "R8 re-armed");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule